// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two timer/counters, numbered 0 and 1, of the kind found beside a small 8-bit processor core. Each keeps its count in a low byte and a high byte. A shared mode register selects, for each timer, one of four counting arrangements, whether it counts machine-cycle strobes or falling edges on an external count pin, and whether an external gate pin may hold it off. A shared control register carries the run bits and the overflow flags. Both flags also leave the block as outputs for an interrupt controller.

Software writes and reads the registers through a simple port. The write is a one-cycle strobe with an address and a data byte. The read is combinational from a separate read address. The two count pins pass through a synchroniser whose depth is a parameter. An acknowledge pulse per timer clears that timer's overflow flag.

Top module: `dual_timer`

## Requirements
- R1: After reset every register reads 0x00 and both overflow outputs are 0. The register map is: address 0 is the control register, 1 the mode register, 2 the timer 0 low byte, 3 the timer 0 high byte, 4 the timer 1 low byte, 5 the timer 1 high byte.
- R2: Mode 0 (mode field 0) chains the high byte to the low 5 bits of the low byte as a 13-bit count. The high byte steps once every 32 counts and the upper 3 low-byte bits keep their value. When the count goes from high byte 0xFF and low 5 bits 0x1F to all zeros, it sets the flag.
- R3: Mode 1 (mode field 1) counts the full 16-bit high:low pair. The step from 0xFFFF to 0x0000 sets the timer's overflow flag.
- R4: Mode 2 (mode field 2) counts the low byte alone. When it overflows from 0xFF, the low byte takes the high byte's value, the flag is set and the high byte is not changed.
- R5: A timer counts only while its run bit is 1 and either its gate bit is 0 or its gate pin is 1. Setting the run bit does not alter the count.
- R6: When the select bit is 1, the timer counts one step per 1-to-0 transition of its count pin (seen after the synchroniser) and ignores the machine-cycle strobe. When the select bit is 0, it counts cycles where the strobe is 1.
- R7: Timer 1 in mode 3 keeps its count unchanged whatever its run bit is.
- R8: With timer 0 in mode 3, the timer 0 low byte is an 8-bit counter under timer 0's controls that sets flag 0. The timer 0 high byte counts machine-cycle strobes while the timer 1 run bit is 1 and sets flag 1. Timer 1, if not in mode 3, counts without its run bit and never sets flag 1.
- R9: A software write of 0 to a flag bit or an acknowledge pulse clears that flag. A hardware set in the same cycle as either clear leaves the flag at 1.
- R10: A software write to a count byte in the same cycle as an increment stores the written value.
- R11: Control register bits, MSB to LSB: flag 1, run 1, flag 0, run 0, then four plain read/write bits. Mode register: bits 7:4 control timer 1 and bits 3:0 control timer 0, each nibble being {gate, select, mode[1:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle machine-cycle strobe |
| cnt_pin | input | 2 | External count pins, bit i for timer i |
| gate_pin | input | 2 | External gate pins, bit i for timer i |
| intack | input | 2 | Interrupt acknowledge pulses, bit i clears flag i |
| wr_en | input | 1 | Register write strobe |
| waddr | input | 3 | Register write address |
| wdata | input | 8 | Register write data |
| raddr | input | 3 | Register read address |
| rdata | output | 8 | Register read data |
| ovf | output | 2 | Overflow flags, bit i for timer i |

## Verification
The bench builds the block with the default two-stage count-pin synchroniser. At that depth a falling edge is counted three clock edges after the pin changes, so short pin pulses of a few cycles each make a countable train. The bench uses them to show that edge counting ignores the strobe. The count bytes are preloaded through the write port, so 16-bit wrap, 13-bit wrap, reload and split-mode overflow are each reached within a few strobes.

// File: rtl/dual_timer.sv
`timescale 1ns/1ps
module dual_timer #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] cnt_pin,
  input  logic [1:0] gate_pin,
  input  logic [1:0] intack,
  input  logic       wr_en,
  input  logic [2:0] waddr,
  input  logic [7:0] wdata,
  input  logic [2:0] raddr,
  output logic [7:0] rdata,
  output logic [1:0] ovf
);

  logic [7:0] ctl, mode, tl0, th0, tl1, th1;
  logic [7:0] tl0_n, th0_n, tl1_n, th1_n, ctl_n;
  logic [SYNC_DEPTH-1:0] sy0, sy1;
  logic [1:0] prv, fall;
  logic set0, set1a, set1b;

  wire [1:0] m0 = mode[1:0];
  wire [1:0] m1 = mode[5:4];
  wire ev0 = mode[2] ? fall[0] : tick;
  wire ev1 = mode[6] ? fall[1] : tick;
  wire run0  = ctl[4] & (~mode[3] | gate_pin[0]) & ev0;
  wire run0h = (m0 == 2'd3) & ctl[6] & tick;
  wire run1  = ((m0 == 2'd3) | ctl[6]) & (~mode[7] | gate_pin[1]) & ev1 & (m1 != 2'd3);

  assign fall = prv & ~{sy1[SYNC_DEPTH-1], sy0[SYNC_DEPTH-1]};
  assign ovf  = {ctl[7], ctl[5]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy0 <= '0;
      sy1 <= '0;
      prv <= '0;
    end else begin
      sy0 <= {sy0[SYNC_DEPTH-2:0], cnt_pin[0]};
      sy1 <= {sy1[SYNC_DEPTH-2:0], cnt_pin[1]};
      prv <= {sy1[SYNC_DEPTH-1], sy0[SYNC_DEPTH-1]};
    end
  end

  always_comb begin
    tl0_n = tl0;
    th0_n = th0;
    set0  = 1'b0;
    set1a = 1'b0;
    case (m0)
      2'd0: if (run0) begin
        tl0_n[4:0] = tl0[4:0] + 5'd1;
        if (&tl0[4:0]) begin
          th0_n = th0 + 8'd1;
          set0  = &th0;
        end
      end
      2'd1: if (run0) begin
        {th0_n, tl0_n} = {th0, tl0} + 16'd1;
        set0 = &{th0, tl0};
      end
      2'd2: if (run0) begin
        tl0_n = (&tl0) ? th0 : tl0 + 8'd1;
        set0  = &tl0;
      end
      default: begin
        if (run0) begin
          tl0_n = tl0 + 8'd1;
          set0  = &tl0;
        end
        if (run0h) begin
          th0_n = th0 + 8'd1;
          set1a = &th0;
        end
      end
    endcase
  end

  always_comb begin
    tl1_n = tl1;
    th1_n = th1;
    set1b = 1'b0;
    if (run1) begin
      case (m1)
        2'd0: begin
          tl1_n[4:0] = tl1[4:0] + 5'd1;
          if (&tl1[4:0]) begin
            th1_n = th1 + 8'd1;
            set1b = &th1;
          end
        end
        2'd1: begin
          {th1_n, tl1_n} = {th1, tl1} + 16'd1;
          set1b = &{th1, tl1};
        end
        2'd2: begin
          tl1_n = (&tl1) ? th1 : tl1 + 8'd1;
          set1b = &tl1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    ctl_n    = (wr_en && waddr == 3'd0) ? wdata : ctl;
    ctl_n[5] = set0 | (ctl_n[5] & ~intack[0]);
    ctl_n[7] = ((m0 == 2'd3) ? set1a : set1b) | (ctl_n[7] & ~intack[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl  <= '0;
      mode <= '0;
      tl0  <= '0;
      th0  <= '0;
      tl1  <= '0;
      th1  <= '0;
    end else begin
      ctl  <= ctl_n;
      mode <= (wr_en && waddr == 3'd1) ? wdata : mode;
      tl0  <= (wr_en && waddr == 3'd2) ? wdata : tl0_n;
      th0  <= (wr_en && waddr == 3'd3) ? wdata : th0_n;
      tl1  <= (wr_en && waddr == 3'd4) ? wdata : tl1_n;
      th1  <= (wr_en && waddr == 3'd5) ? wdata : th1_n;
    end
  end

  always_comb begin
    case (raddr)
      3'd0:    rdata = ctl;
      3'd1:    rdata = mode;
      3'd2:    rdata = tl0;
      3'd3:    rdata = th0;
      3'd4:    rdata = tl1;
      3'd5:    rdata = th1;
      default: rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/dual_timer_chk.sv
`timescale 1ns/1ps
module dual_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] mode,
  input logic [7:0] tl0,
  input logic [7:0] th0,
  input logic [7:0] tl1,
  input logic [7:0] th1,
  input logic [1:0] ovf,
  input logic [1:0] gate_pin,
  input logic       wr_en,
  input logic [2:0] waddr,
  input logic       run0,
  input logic       run0h
);

  wire wr_t0 = wr_en && (waddr == 3'd2 || waddr == 3'd3);
  wire wr_t1 = wr_en && (waddr == 3'd4 || waddr == 3'd5);

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1:0] == 2'd2 && run0 && tl0 == 8'hFF && !wr_t0) |=> (tl0 == $past(th0) && th0 == $past(th0) && ovf[0]));

  assert_wrap_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1:0] == 2'd1 && run0 && {th0, tl0} == 16'hFFFF) |=> ovf[0]);

  assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run0 && !run0h && !wr_t0) |=> ($stable(tl0) && $stable(th0)));

  assert_gate_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[3] && !gate_pin[0] && mode[1:0] != 2'd3 && !wr_t0) |=> $stable({th0, tl0}));

  assert_t1_mode3_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[5:4] == 2'd3 && !wr_t1) |=> $stable({th1, tl1}));

  assert_split_high_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1:0] == 2'd3 && run0h && th0 == 8'hFF) |=> ovf[1]);

endmodule

bind dual_timer dual_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .tl0(tl0), .th0(th0), .tl1(tl1), .th1(th1),
  .ovf(ovf), .gate_pin(gate_pin), .wr_en(wr_en), .waddr(waddr), .run0(run0), .run0h(run0h)
);

// File: tb/tb_dual_timer.sv
`timescale 1ns/1ps
module tb_dual_timer;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [1:0] cnt_pin = 2'b11, gate_pin = 2'b00, intack = 2'b00, ovf;
  logic [2:0] waddr = 0, raddr = 0;
  logic [7:0] wdata = 0, rdata;
  int checks = 0, failures = 0;
  bit done = 0;
  int    qa[$];
  int    qe[$];
  string qt[$];

  dual_timer dut (.clk(clk), .rst_n(rst_n), .tick(tick), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .intack(intack), .wr_en(wr_en), .waddr(waddr), .wdata(wdata), .raddr(raddr), .rdata(rdata), .ovf(ovf));

  always #10 clk = ~clk;

  // monitor: address 8 stands for the ovf output
  always @(negedge clk) begin
    if (qa.size() > 0) begin
      int a, e, got;
      string t;
      a = qa.pop_front(); e = qe.pop_front(); t = qt.pop_front();
      if (a < 8) raddr = a[2:0];
      #1;
      got = (a == 8) ? int'(ovf) : int'(rdata);
      checks++;
      if (got !== e) begin
        failures++;
        $display("FAIL %s addr=%0d actual=0x%0h expected=0x%0h", t, a, got, e);
      end
    end
  end

  task automatic expect_val(input int a, input int e, input string t);
    qa.push_back(a); qe.push_back(e); qt.push_back(t);
    while (qa.size() != 0) @(posedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1; waddr = a[2:0]; wdata = d[7:0];
    @(negedge clk); wr_en = 0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin tick = 1; @(negedge clk); end
    tick = 0;
  endtask

  task automatic wr_tick(input int a, input int d);
    @(negedge clk); wr_en = 1; waddr = a[2:0]; wdata = d[7:0]; tick = 1;
    @(negedge clk); wr_en = 0; tick = 0;
  endtask

  task automatic ack(input logic [1:0] v, input bit with_tick);
    @(negedge clk); intack = v; tick = with_tick;
    @(negedge clk); intack = 0; tick = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 6; a++) expect_val(a, 0, "R1 reset register");
    expect_val(8, 0, "R1 reset ovf");

    // mode 1, timer 0
    wr(1, 8'h01); wr(2, 8'hFE); wr(3, 8'hFF); wr(0, 8'h10);
    expect_val(2, 8'hFE, "R5 run set keeps count");
    ticks(1);
    expect_val(2, 8'hFF, "R3 count step");
    expect_val(8, 0, "R3 no flag before wrap");
    ticks(1);
    expect_val(2, 8'h00, "R3 wrap low");
    expect_val(3, 8'h00, "R3 wrap high");
    expect_val(0, 8'h30, "R11 flag0 position");
    expect_val(8, 1, "R3 ovf out");

    // flag clears
    wr(0, 8'h10);
    expect_val(8, 0, "R9 write-0 clear");
    wr(2, 8'hFF); wr(3, 8'hFF);
    ack(2'b01, 1);
    expect_val(8, 1, "R9 set wins over ack");
    ack(2'b01, 0);
    expect_val(8, 0, "R9 ack clear");

    // write priority (count is 0000 after wrap)
    wr_tick(2, 8'h40);
    expect_val(2, 8'h40, "R10 write beats increment");
    expect_val(3, 8'h00, "R10 high untouched");

    // mode 0
    wr(0, 0); wr(1, 8'h00); wr(2, 8'hFE); wr(3, 8'h00); wr(0, 8'h10);
    ticks(3);
    expect_val(2, 8'hE1, "R2 prescale low");
    expect_val(3, 8'h01, "R2 prescale carry");
    wr(3, 8'hFF); wr(2, 8'hFF);
    ticks(1);
    expect_val(2, 8'hE0, "R2 13-bit wrap low");
    expect_val(3, 8'h00, "R2 13-bit wrap high");
    expect_val(8, 1, "R2 13-bit wrap flag");
    wr(0, 0);

    // mode 2
    wr(1, 8'h02); wr(3, 8'h9C); wr(2, 8'hFE); wr(0, 8'h10);
    ticks(1);
    expect_val(8, 0, "R4 no flag yet");
    ticks(1);
    expect_val(2, 8'h9C, "R4 reload");
    expect_val(3, 8'h9C, "R4 high unchanged");
    expect_val(8, 1, "R4 flag");
    ticks(3);
    expect_val(2, 8'h9F, "R4 count after reload");
    wr(0, 0);

    // gate
    wr(1, 8'h09); wr(2, 0); wr(3, 0); wr(0, 8'h10);
    ticks(5);
    expect_val(2, 0, "R5 gate pin low blocks");
    @(negedge clk); gate_pin = 2'b01;
    ticks(5);
    expect_val(2, 5, "R5 gate pin high counts");
    wr(0, 0);
    ticks(5);
    expect_val(2, 5, "R5 run bit low blocks");
    @(negedge clk); gate_pin = 2'b00;

    // counter mode, timer 1
    wr(1, 8'h50); wr(4, 0); wr(5, 0); wr(0, 8'h40);
    for (int p = 0; p < 3; p++) begin
      @(negedge clk); cnt_pin[1] = 0; tick = 1;
      repeat (4) @(negedge clk);
      cnt_pin[1] = 1;
      repeat (4) @(negedge clk);
    end
    tick = 0;
    repeat (5) @(negedge clk);
    expect_val(4, 3, "R6 falling edges counted, strobe ignored");
    expect_val(5, 0, "R6 high byte");

    // timer 1 mode 3 holds
    wr(1, 8'h30);
    ticks(5);
    expect_val(4, 3, "R7 timer1 mode3 holds");

    // split mode
    wr(0, 0);
    wr(1, 8'h13); wr(2, 8'hFE); wr(3, 8'hFF); wr(4, 8'hFF); wr(5, 8'hFF); wr(0, 8'h10);
    ticks(2);
    expect_val(2, 8'h00, "R8 low byte wraps");
    expect_val(3, 8'hFF, "R8 high byte idle without run1");
    expect_val(4, 8'h01, "R8 timer1 runs without run bit");
    expect_val(5, 8'h00, "R8 timer1 high");
    expect_val(0, 8'h30, "R8 timer1 wrap sets no flag");
    wr(0, 8'h40);
    ticks(1);
    expect_val(3, 8'h00, "R8 high byte counts on run1");
    expect_val(2, 8'h00, "R8 low byte stopped");
    expect_val(0, 8'hC0, "R8 flag1 from high byte");
    expect_val(8, 2, "R8 ovf out");

    // plain control bits and mode readback
    wr(0, 8'h05);
    expect_val(0, 8'h05, "R11 low control bits stored");
    expect_val(1, 8'h13, "R11 mode readback");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule